// File: doc/BRIEF.md
# Engine Soft-Reset Controller with Host Access Gating

This block sits between a host bus and two terminal engines. It holds one control/status word. Software starts a soft reset of an engine by writing a 1 to that engine's launch bit. The block then sends the engine a one-cycle pulse that clears its start-execution flag. After that it holds a reset request until the engine reports completion. The launch bit stays set for the whole sequence and clears itself when the engine reports done.

While any engine is resetting, the block holds its `ready` output low and blocks every host write, both to its own word and to the downstream registers and RAM. During that time every host read returns the control/status word, whatever the address. When all resets are finished, `ready` rises and host traffic passes through again. The word also shows six activity flags that the engines supply, and it shows the current `ready` level in its top bit.

Host accesses are single-cycle strobes. Read data is combinational from the address. Any address other than the control/status word is forwarded to a downstream port.

Top module: `softrst_ctl`

## Requirements
- R1: After reset, `ready` is 1, `stex_clr` and `eng_rst_req` are 0, and the control/status word reads 16'h8000 when all activity inputs are 0.
- R2: A host write to the control word with bit 11 set (engine 0) or bit 10 set (engine 1), accepted at a clock edge, makes that engine's `stex_clr` high for exactly the next cycle. In that cycle the launch bit already reads 1.
- R3: `eng_rst_req` of a launched engine rises in the cycle after its `stex_clr` pulse. It stays high up to and including the cycle in which `eng_rst_done` is sampled high.
- R4: A launch bit reads 1 from the write until the edge at which done is sampled during the request, then reads 0. `ready` returns to 1 at the same edge, when no other engine is busy. With a done latency of L cycles, `ready` is low for 2+L cycles.
- R5: While any launch bit is 1, `ready` is 0 and bit 15 of the word reads 0. When idle, bit 15 reads 1.
- R6: While `ready` is 0, a host read at any address returns the control/status word.
- R7: While `ready` is 0, host writes have no effect. `dn_wr` and `dn_rd` stay 0, and a write to the control word neither launches nor changes anything.
- R8: While `ready` is 1, reads at any address other than the control word return `dn_rdata`, and `dn_rd`/`dn_wr` follow the host strobes. Reads at the control word address (0) return the word.
- R9: Bits 9..4 of the word show `act_in[5:0]` (bit 4 is `act_in[0]`). Writes to these bits have no effect.
- R10: Writing 0 to a launch bit starts nothing. Bits 14..12 and 3..0 always read 0.
- R11: A single write with both bits 11 and 10 set starts both engines in the same cycle. `ready` stays low until both have reported done, that is, for 2+max(L0,L1) cycles.
- R12: `eng_rst_done` is ignored while an engine is idle or in its start-execution clear cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | ADDR_W | Host word address |
| host_wdata | input | 16 | Host write data |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 16 | Host read data (combinational) |
| ready | output | 1 | High when no engine reset is in progress |
| dn_wr | output | 1 | Gated write strobe to downstream space |
| dn_rd | output | 1 | Gated read strobe to downstream space |
| dn_rdata | input | 16 | Downstream read data |
| act_in | input | 6 | Engine activity flags |
| stex_clr | output | 2 | Per-engine start-execution clear pulse |
| eng_rst_req | output | 2 | Per-engine soft-reset request |
| eng_rst_done | input | 2 | Per-engine reset completion |

## Verification
A sequencer stuck in its request state shows at the ports as `ready` held low past the 2+L cycles that the done latency predicts. A sequencer that leaves too early drops its launch bit before `eng_rst_req` has seen done. Both show up within one cycle of the expected edge, because the bench counts busy cycles against the latency of the stub engine. A gate that leaks shows in the same cycle as a wrong read value at some address, or as a downstream strobe while busy. A leaked control-word write shows within three cycles as an unexpected relaunch once `ready` has returned.

// File: rtl/softrst_pkg.sv
package softrst_pkg;
  localparam int unsigned DATA_W         = 16;
  localparam int unsigned N_ENG          = 2;
  localparam int unsigned ACT_W          = 6;
  localparam int unsigned ACT_LSB        = 4;
  localparam int unsigned READY_BIT      = 15;
  localparam int unsigned LAUNCH_BIT_TOP = 11;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_CLR  = 2'd1,
    SEQ_RUN  = 2'd2
  } seq_state_e;

  // Engine i owns bit (LAUNCH_BIT_TOP - i) of the control word.
  function automatic int unsigned launch_bit(input int unsigned eng);
    return LAUNCH_BIT_TOP - eng;
  endfunction

  function automatic logic [DATA_W-1:0] pack_status(
    input logic             rdy,
    input logic [N_ENG-1:0] busy,
    input logic [ACT_W-1:0] act
  );
    logic [DATA_W-1:0] w;
    w = '0;
    w[READY_BIT] = rdy;
    for (int unsigned i = 0; i < N_ENG; i++) begin
      w[launch_bit(i)] = busy[i];
    end
    w[ACT_LSB +: ACT_W] = act;
    return w;
  endfunction
endpackage

// File: rtl/softrst_eng_seq.sv
module softrst_eng_seq
  import softrst_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  logic done_in,
  output logic busy,
  output logic stex_clr,
  output logic rst_req,
  output logic finish
);
  seq_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SEQ_IDLE: if (launch)  st_d = SEQ_CLR;
      SEQ_CLR:               st_d = SEQ_RUN;
      SEQ_RUN:  if (done_in) st_d = SEQ_IDLE;
      default:               st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SEQ_IDLE;
    else        st_q <= st_d;
  end

  assign busy     = (st_q != SEQ_IDLE);
  assign stex_clr = (st_q == SEQ_CLR);
  assign rst_req  = (st_q == SEQ_RUN);
  assign finish   = rst_req & done_in;

  AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    stex_clr |=> !stex_clr); // R2
  AST_REQ_FOLLOWS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    stex_clr |=> rst_req); // R3
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req && !done_in |=> rst_req); // R3
  AST_RELEASE_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req && done_in |=> !busy); // R4
  AST_EARLY_DONE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    stex_clr && done_in |=> busy); // R12
endmodule

// File: rtl/softrst_host_gate.sv
module softrst_host_gate
  import softrst_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned CSR_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic              ready,
  input  logic [DATA_W-1:0] csr_word,
  input  logic [DATA_W-1:0] dn_rdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              dn_wr,
  output logic              dn_rd,
  output logic [N_ENG-1:0]  launch
);
  localparam logic [ADDR_W-1:0] CSR_A = ADDR_W'(CSR_ADDR);

  logic csr_sel;
  logic csr_wr_ok;

  assign csr_sel   = (host_addr == CSR_A);
  assign csr_wr_ok = host_wr & ready & csr_sel;
  assign dn_wr     = host_wr & ready & ~csr_sel;
  assign dn_rd     = host_rd & ready & ~csr_sel;

  // While held, the status word overrides every address.
  assign host_rdata = (!ready || csr_sel) ? csr_word : dn_rdata;

  for (genvar g = 0; g < N_ENG; g++) begin : g_launch
    assign launch[g] = csr_wr_ok & host_wdata[launch_bit(g)];
  end

  AST_NO_ACCESS_WHEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !dn_wr && !dn_rd && (launch == '0)); // R7
  AST_READ_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && !ready |-> host_rdata == csr_word); // R6
endmodule

// File: rtl/softrst_ctl.sv
module softrst_ctl
  import softrst_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned CSR_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [15:0]       host_wdata,
  input  logic              host_wr,
  input  logic              host_rd,
  output logic [15:0]       host_rdata,
  output logic              ready,
  output logic              dn_wr,
  output logic              dn_rd,
  input  logic [15:0]       dn_rdata,
  input  logic [5:0]        act_in,
  output logic [1:0]        stex_clr,
  output logic [1:0]        eng_rst_req,
  input  logic [1:0]        eng_rst_done
);
  logic [N_ENG-1:0]  launch;
  logic [N_ENG-1:0]  busy;
  logic [N_ENG-1:0]  finish;
  logic [DATA_W-1:0] csr_word;

  for (genvar g = 0; g < N_ENG; g++) begin : g_eng
    softrst_eng_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .launch   (launch[g]),
      .done_in  (eng_rst_done[g]),
      .busy     (busy[g]),
      .stex_clr (stex_clr[g]),
      .rst_req  (eng_rst_req[g]),
      .finish   (finish[g])
    );
  end

  assign ready    = ~|busy;
  assign csr_word = pack_status(ready, busy, act_in);

  softrst_host_gate #(
    .ADDR_W   (ADDR_W),
    .CSR_ADDR (CSR_ADDR)
  ) u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .ready      (ready),
    .csr_word   (csr_word),
    .dn_rdata   (dn_rdata),
    .host_rdata (host_rdata),
    .dn_wr      (dn_wr),
    .dn_rd      (dn_rd),
    .launch     (launch)
  );

  AST_LAUNCH_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    |launch |=> !ready); // R5
  AST_BOTH_START: assert property (@(posedge clk) disable iff (!rst_n)
    &launch |=> &busy); // R11
  AST_LAST_FINISH_RAISES_READY: assert property (@(posedge clk) disable iff (!rst_n)
    finish == busy && |finish |=> ready); // R4
endmodule

// File: tb/softrst_ctl_bench.sv
`timescale 1ns/100ps
module softrst_ctl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [15:0] rdata;
  logic        ready, dn_wr, dn_rd;
  logic [15:0] dn_rdata;
  logic [5:0]  act = '0;
  logic [1:0]  stex_clr, rst_req, done;
  logic [1:0]  spur = '0, stex_set = '0, stex;
  logic [1:0][3:0] cnt, lat;
  int n_chk = 0, n_bad = 0;
  localparam logic [3:0] CSR_A = 4'h0;

  always #4 clk = ~clk;

  assign dn_rdata = 16'h5A00 ^ {12'h0, addr};

  softrst_ctl u_softrst_ctl (
    .clk(clk), .rst_n(rst_n), .host_addr(addr), .host_wdata(wdata),
    .host_wr(wr), .host_rd(rd), .host_rdata(rdata), .ready(ready),
    .dn_wr(dn_wr), .dn_rd(dn_rd), .dn_rdata(dn_rdata), .act_in(act),
    .stex_clr(stex_clr), .eng_rst_req(rst_req), .eng_rst_done(done)
  );

  // Stub engines: done after lat cycles of request; start-execution flag model.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      stex <= '0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (!rst_req[i]) cnt[i] <= '0;
        else if (!done[i]) cnt[i] <= cnt[i] + 4'd1;
        if (stex_clr[i]) stex[i] <= 1'b0;
        else if (stex_set[i]) stex[i] <= 1'b1;
      end
    end
  end
  always_comb begin
    for (int i = 0; i < 2; i++) done[i] = (rst_req[i] && cnt[i] == lat[i]) || spur[i];
  end

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [15:0] word(input logic rdy, input logic b0, input logic b1,
                                       input logic [5:0] a);
    return {rdy, 3'b000, b0, b1, a, 4'b0000};
  endfunction

  task automatic read_at(input logic [3:0] a, output logic [15:0] v);
    addr = a; rd = 1'b1; #0.2; v = rdata; rd = 1'b0;
  endtask

  task automatic run_reset(input logic [1:0] mask, input int l0, input int l1,
                           input logic spur_clr, input logic poke, input string tag);
    int exp_len, k;
    int clr_seen [2];
    int req_seen [2];
    int lt [2];
    logic [15:0] v;
    lt[0] = l0; lt[1] = l1;
    clr_seen[0] = 0; clr_seen[1] = 0; req_seen[0] = 0; req_seen[1] = 0;
    lat[0] = 4'(l0); lat[1] = 4'(l1);
    stex_set = mask; @(negedge clk); stex_set = '0;
    exp_len = 0;
    for (int i = 0; i < 2; i++) if (mask[i] && 2 + lt[i] > exp_len) exp_len = 2 + lt[i];
    addr = CSR_A; wdata = {4'b0000, mask[0], mask[1], 10'b0}; wr = 1'b1;
    @(negedge clk); wr = 1'b0; wdata = '0;
    k = 0;
    while (!ready && k < 40) begin
      k++;
      spur = (spur_clr && k == 1) ? mask : 2'b00;
      if (k == 1) chk({tag, " R2 clear pulse"}, {14'b0, stex_clr}, {14'b0, mask});
      for (int i = 0; i < 2; i++) begin
        if (stex_clr[i]) clr_seen[i]++;
        if (rst_req[i]) req_seen[i]++;
      end
      for (int a = 0; a < 16; a++) begin
        read_at(4'(a), v);
        chk({tag, " R6 R5 held read"}, v,
            word(1'b0, mask[0] && k <= 2 + lt[0], mask[1] && k <= 2 + lt[1], act));
      end
      if (poke) begin
        addr = 4'h3; wr = 1'b1; #0.2;
        chk({tag, " R7 dn_wr blocked"}, {15'b0, dn_wr}, 16'h0000);
        addr = CSR_A; wdata = 16'hFFFF;
      end
      @(negedge clk); wr = 1'b0; spur = '0; wdata = '0;
    end
    chk({tag, " R4 R11 busy length"}, 16'(k), 16'(exp_len));
    for (int i = 0; i < 2; i++) begin
      chk({tag, " R2 single clear"}, 16'(clr_seen[i]), mask[i] ? 16'd1 : 16'd0);
      chk({tag, " R3 request length"}, 16'(req_seen[i]), mask[i] ? 16'(1 + lt[i]) : 16'd0);
    end
    chk({tag, " R2 stex cleared"}, {14'b0, stex & mask}, 16'h0000);
    read_at(CSR_A, v);
    chk({tag, " R4 word after"}, v, word(1'b1, 1'b0, 1'b0, act));
    @(negedge clk);
    chk({tag, " R7 no relaunch"}, {15'b0, ready}, 16'h0001);
  endtask

  initial begin
    logic [15:0] v;
    lat = '0;
    #20; @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", {15'b0, ready}, 16'h0001);
    chk("R1 strobes", {12'b0, stex_clr, rst_req}, 16'h0000);
    read_at(CSR_A, v);
    chk("R1 word", v, 16'h8000);

    // R8 pass-through sweep while ready
    for (int a = 0; a < 16; a++) begin
      addr = 4'(a); rd = 1'b1; #0.2;
      chk("R8 rdata", rdata, (a == 0) ? 16'h8000 : (16'h5A00 ^ 16'(a)));
      chk("R8 dn_rd", {15'b0, dn_rd}, (a == 0) ? 16'h0 : 16'h1);
      rd = 1'b0; wr = 1'b1; #0.2;
      chk("R8 dn_wr", {15'b0, dn_wr}, (a == 0) ? 16'h0 : 16'h1);
      wr = 1'b0;
    end

    // R9 activity flags sweep
    for (int f = 0; f < 64; f++) begin
      act = 6'(f); read_at(CSR_A, v);
      chk("R9 R5 flags", v, word(1'b1, 1'b0, 1'b0, 6'(f)));
    end

    // R10 R9 writes of zeros / read-only bits
    act = 6'b101101;
    addr = CSR_A; wdata = 16'hF3FF; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    chk("R10 no launch", {14'b0, stex_clr}, 16'h0000);
    @(negedge clk);
    chk("R10 ready kept", {15'b0, ready}, 16'h0001);
    read_at(CSR_A, v);
    chk("R10 R9 word", v, word(1'b1, 1'b0, 1'b0, act));

    // R12 stray done while idle
    spur = 2'b11; @(negedge clk); @(negedge clk); spur = '0;
    chk("R12 idle done", {13'b0, ready, stex_clr}, 16'h0004);

    // R2 R3 R4 single-engine sweeps
    for (int l = 0; l < 6; l++) begin
      run_reset(2'b01, l, 0, 1'b0, 1'b0, "eng0");
      run_reset(2'b10, 0, l, 1'b0, 1'b0, "eng1");
    end
    // R11 both engines, all latency pairs, with held writes (R7)
    for (int a = 0; a < 6; a++)
      for (int b = 0; b < 6; b++)
        run_reset(2'b11, a, b, 1'b0, (a + b) % 2 == 1, "both");
    // R12 done during the clear cycle
    for (int l = 0; l < 4; l++) run_reset(2'b11, l, 3 - l, 1'b1, 1'b1, "early");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule